// File: doc/BRIEF.md
# Serial Packet Framer with Run-Length Stuffing and NRZI Line Coding

This block produces the transmit bit stream of a short-range wideband serial link. It emits one line bit per clock, and it builds each packet from three parts: an alternating synchronisation header, a short start marker, and a fixed-length body. In normal mode the body comes from a reseeded pseudo-random generator, so a receiver can count bit errors against its own copy of the sequence. In debug mode the body is a regular square pattern.

Before line coding, a stuffer forces a transition after every run of identical bits that reaches the limit. The stuffed stream then drives an NRZI encoder. After each packet the framer stays idle for a fixed gap and spends one cycle re-initialising its parts. It then starts the next packet without outside help.

The only control input is the mode select. The mode is captured once per packet, while the last header bit is being taken.

Top module: `bcl_pkt_framer`

## Requirements
- R1: While rst_n is low, line_out and pkt_active are 0 at the next clock edge. After release, the first packet begins at once.
- R2: Each packet opens with HDR_LEN (80) header bits that alternate and start with 1 (header bit i is 1 for even i).
- R3: After the header come MARK_LEN (4) marker bits, equal to MARK_CODE (4'b1101) and sent most significant bit first.
- R4: The body has BODY_LEN (1000) data bits. In normal mode, body bit j is bit 14 of a 15-bit register that starts at SEED (15'h1ACE) for every packet. After each data bit the register becomes {r[13:0], r[14]^r[13]}.
- R5: In debug mode, body bit j is 1 when (j mod 8) < 4 and 0 otherwise.
- R6: test_mode is captured on the edge that takes the last header bit. A change at any other time does not alter the body of that packet.
- R7: The stuffed stream never holds more than MAX_RUN (3) equal bits in a row. After MAX_RUN equal bits, the complement of that value is inserted. The inserted bit is not a data bit, and the data sequence pauses while it is sent.
- R8: line_out toggles for a stuffed-stream 1 and holds for a 0. The line is 0 just before the first bit of every packet.
- R9: pkt_active is 1 exactly in the cycles that carry packet bits. Between two packets it is 0 for GAP_LEN+1 (201) cycles, and line_out does not change in that time except to return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| test_mode | input | 1 | Body source select: 0 pseudo-random, 1 debug pattern |
| line_out | output | 1 | NRZI-coded serial line bit |
| pkt_active | output | 1 | High while line_out carries a packet bit |

## Verification
Every line bit comes out of a single register stage. The bit the sequencer selects before edge n appears on line_out and pkt_active after edge n, so each result is due one cycle after its source is chosen.

The bench samples on the falling edge and decodes each sample against the previous one. It removes stuffed bits by its own run count and compares every data bit with a model built from the requirements. Mode changes are driven on the falling edge. The value meant for a packet is held from header bit 60 through the marker, so the capture edge sees it. Gap length and the line level before each packet are checked when pkt_active rises.

// File: rtl/bcl_pkg.sv
// Shared types for the serial packet framer.
package bcl_pkg;
    typedef enum logic [2:0] {
        ST_HDR,
        ST_MARK,
        ST_BODY,
        ST_GAP,
        ST_CLR
    } seq_st_t;
endpackage

// File: rtl/bcl_seq.sv
// Frame sequencer: walks header, marker, body, gap and a one-cycle clear.
// Assumes the stall input only rises while a packet bit is being sent.
// Captures the mode select on the edge that takes the last header bit.
module bcl_seq
    import bcl_pkg::*;
#(
    parameter int HDR_LEN  = 80,
    parameter int MARK_LEN = 4,
    parameter int BODY_LEN = 1000,
    parameter int GAP_LEN  = 200,
    parameter int CW       = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stall,
    input  logic          test_mode,
    output seq_st_t       st,
    output logic [CW-1:0] cnt,
    output logic          active,
    output logic          adv,
    output logic          pkt_clr,
    output logic          mode_q
);
    localparam logic [CW-1:0] HDR_LAST  = CW'(HDR_LEN - 1);
    localparam logic [CW-1:0] MARK_LAST = CW'(MARK_LEN - 1);
    localparam logic [CW-1:0] BODY_LAST = CW'(BODY_LEN - 1);
    localparam logic [CW-1:0] GAP_LAST  = CW'(GAP_LEN - 1);

    // Decode which cycles carry packet bits and whether a data bit is taken.
    always_comb begin
        active  = (st == ST_HDR) || (st == ST_MARK) || (st == ST_BODY);
        adv     = active && !stall;
        pkt_clr = (st == ST_CLR);
    end

    // State, position counter and mode capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_HDR;
            cnt    <= '0;
            mode_q <= 1'b0;
        end else begin
            case (st)
                ST_HDR: if (adv) begin
                    if (cnt == HDR_LAST) begin
                        st     <= ST_MARK;
                        cnt    <= '0;
                        mode_q <= test_mode;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_MARK: if (adv) begin
                    if (cnt == MARK_LAST) begin
                        st  <= ST_BODY;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_BODY: if (adv) begin
                    if (cnt == BODY_LAST) begin
                        st  <= ST_GAP;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_GAP: begin
                    if (cnt == GAP_LAST) begin
                        st  <= ST_CLR;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    st  <= ST_HDR;
                    cnt <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/bcl_body_src.sv
// Body bit source: a 15-bit maximal-length LFSR or a square debug pattern.
// The LFSR reloads its seed on each packet clear and steps once per body data bit.
module bcl_body_src #(
    parameter logic [14:0] SEED = 15'h1ACE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload,
    input  logic step,
    input  logic mode,
    input  logic pat_phase,
    output logic body_bit
);
    logic [14:0] lfsr;

    // Shift register for the pseudo-random sequence, taps 15 and 14.
    always_ff @(posedge clk) begin
        if (!rst_n || reload) begin
            lfsr <= SEED;
        end else if (step) begin
            lfsr <= {lfsr[13:0], lfsr[14] ^ lfsr[13]};
        end
    end

    // Pick the source: debug pattern is 1 for the first half of each 8-bit period.
    always_comb begin
        body_bit = mode ? ~pat_phase : lfsr[14];
    end
endmodule

// File: rtl/bcl_stuffer.sv
// Run-length stuffer: after MAX_RUN equal bits it sends the complement.
// The caller stalls its source in that cycle. The run restarts on packet clear.
module bcl_stuffer #(
    parameter int MAX_RUN = 3,
    parameter int RW      = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic active,
    input  logic src_bit,
    output logic stuff_now,
    output logic out_bit
);
    localparam logic [RW-1:0] RUN_LIM = RW'(MAX_RUN);

    logic [RW-1:0] run;
    logic          last;

    // Insert a complement once the run limit is reached.
    always_comb begin
        stuff_now = active && (run == RUN_LIM);
        out_bit   = stuff_now ? ~last : src_bit;
    end

    // Track length and value of the current run of the stuffed stream.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            run  <= '0;
            last <= 1'b0;
        end else if (active) begin
            if ((run != '0) && (out_bit == last)) begin
                run <= run + 1'b1;
            end else begin
                run <= RW'(1);
            end
            last <= out_bit;
        end
    end
endmodule

// File: rtl/bcl_nrzi.sv
// NRZI line encoder: toggles on 1, holds on 0, starts at 0 after any clear.
module bcl_nrzi (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic bit_in,
    output logic line,
    output logic act
);
    // Register the line level and the packet-active flag together.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            line <= 1'b0;
            act  <= 1'b0;
        end else begin
            act <= en;
            if (en) begin
                line <= line ^ bit_in;
            end
        end
    end
endmodule

// File: rtl/bcl_pkt_framer.sv
// Top of the serial packet framer. Selects the frame bit, stuffs it and NRZI-codes it.
// Assumes test_mode is synchronous to clk. Outputs are registered.
module bcl_pkt_framer
    import bcl_pkg::*;
#(
    parameter int          HDR_LEN   = 80,
    parameter int          MARK_LEN  = 4,
    parameter logic [3:0]  MARK_CODE = 4'b1101,
    parameter int          BODY_LEN  = 1000,
    parameter int          GAP_LEN   = 200,
    parameter int          MAX_RUN   = 3,
    parameter logic [14:0] SEED      = 15'h1ACE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic test_mode,
    output logic line_out,
    output logic pkt_active
);
    localparam int CW = $clog2(HDR_LEN + MARK_LEN + BODY_LEN + GAP_LEN + 8);
    localparam int RW = $clog2(MAX_RUN + 1);

    seq_st_t       seq_st;
    logic [CW-1:0] seg_cnt;
    logic          seq_active;
    logic          seq_adv;
    logic          pkt_clr;
    logic          mode_q;
    logic          stuff_now;
    logic          body_bit;
    logic          frame_bit;
    logic          line_bit;
    logic          in_hdr;
    logic [3:0]    mark_sh;

    bcl_seq #(
        .HDR_LEN (HDR_LEN),
        .MARK_LEN(MARK_LEN),
        .BODY_LEN(BODY_LEN),
        .GAP_LEN (GAP_LEN),
        .CW      (CW)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .stall    (stuff_now),
        .test_mode(test_mode),
        .st       (seq_st),
        .cnt      (seg_cnt),
        .active   (seq_active),
        .adv      (seq_adv),
        .pkt_clr  (pkt_clr),
        .mode_q   (mode_q)
    );

    bcl_body_src #(
        .SEED(SEED)
    ) src_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload   (pkt_clr),
        .step     (seq_adv && (seq_st == ST_BODY)),
        .mode     (mode_q),
        .pat_phase(seg_cnt[2]),
        .body_bit (body_bit)
    );

    // Select the unstuffed frame bit for the current segment position.
    always_comb begin
        in_hdr  = (seq_st == ST_HDR);
        mark_sh = MARK_CODE << seg_cnt;
        case (seq_st)
            ST_HDR:  frame_bit = ~seg_cnt[0];
            ST_MARK: frame_bit = mark_sh[3];
            ST_BODY: frame_bit = body_bit;
            default: frame_bit = 1'b0;
        endcase
    end

    bcl_stuffer #(
        .MAX_RUN(MAX_RUN),
        .RW     (RW)
    ) stuff_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (pkt_clr),
        .active   (seq_active),
        .src_bit  (frame_bit),
        .stuff_now(stuff_now),
        .out_bit  (line_bit)
    );

    bcl_nrzi nrzi_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pkt_clr),
        .en    (seq_active),
        .bit_in(line_bit),
        .line  (line_out),
        .act   (pkt_active)
    );
endmodule

// File: rtl/bcl_pkt_framer_chk.sv
// Property checker for the framer, attached to the top by bind.
// Decodes the NRZI line itself and tracks the run length of the stuffed stream.
module bcl_pkt_framer_chk #(
    parameter int MAX_RUN = 3,
    parameter int CW      = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          line_out,
    input logic          pkt_active,
    input logic          stuff_now,
    input logic          in_hdr,
    input logic          mode_q,
    input logic [CW-1:0] seg_cnt
);
    logic       prev_line;
    logic       prev_act;
    logic       last_bit;
    logic [7:0] run_len;
    logic       dec_bit;

    assign dec_bit = line_out ^ prev_line;

    // Rebuild the stuffed stream run length from the coded line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_line <= 1'b0;
            prev_act  <= 1'b0;
            last_bit  <= 1'b0;
            run_len   <= '0;
        end else begin
            prev_line <= line_out;
            prev_act  <= pkt_active;
            if (!pkt_active) begin
                run_len <= '0;
            end else begin
                last_bit <= dec_bit;
                if (prev_act && (dec_bit == last_bit)) begin
                    run_len <= run_len + 8'd1;
                end else begin
                    run_len <= 8'd1;
                end
            end
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!line_out && !pkt_active)); // R1
    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n) run_len <= 8'(MAX_RUN)); // R7
    AST_STUFF_STALLS: assert property (@(posedge clk) disable iff (!rst_n) stuff_now |=> $stable(seg_cnt)); // R7
    AST_FIRST_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n) $rose(pkt_active) |-> line_out); // R8
    AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!pkt_active && !$past(pkt_active)) |-> ($stable(line_out) || !line_out)); // R9
    AST_MODE_ONCE: assert property (@(posedge clk) disable iff (!rst_n) !$stable(mode_q) |-> $past(in_hdr)); // R6
endmodule

bind bcl_pkt_framer bcl_pkt_framer_chk #(
    .MAX_RUN(MAX_RUN),
    .CW     (CW)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_out  (line_out),
    .pkt_active(pkt_active),
    .stuff_now (stuff_now),
    .in_hdr    (in_hdr),
    .mode_q    (mode_q),
    .seg_cnt   (seg_cnt)
);

// File: tb/bcl_pkt_framer_tb.sv
// Self-checking bench: decodes NRZI, removes stuffed bits, compares with a frame model.
module bcl_pkt_framer_tb_top;
    localparam int         HDR    = 80;
    localparam int         MARK   = 4;
    localparam logic [3:0] MCODE  = 4'b1101;
    localparam int         BODY   = 1000;
    localparam int         GAP    = 200;
    localparam int         MAXRUN = 3;
    localparam logic [14:0] SEED  = 15'h1ACE;
    localparam int         NPKT   = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic test_mode = 1'b0;
    logic line_out;
    logic pkt_active;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    bcl_pkt_framer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .test_mode (test_mode),
        .line_out  (line_out),
        .pkt_active(pkt_active)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [14:0] lfsr_next(input logic [14:0] r);
        return {r[13:0], r[14] ^ r[13]};
    endfunction

    // Expected data bit at frame index i (R2, R3, R4, R5).
    function automatic bit exp_bit(input int i, input bit m, input logic [14:0] r);
        int j;
        if (i < HDR) return (i % 2) == 0;
        if (i < HDR + MARK) return MCODE[MARK - 1 - (i - HDR)];
        j = i - HDR - MARK;
        if (m) return (j % 8) < 4;
        return r[14];
    endfunction

    function automatic string seg_req(input int i, input bit m);
        if (i < HDR) return "R2";
        if (i < HDR + MARK) return "R3";
        return m ? "R5/R6" : "R4/R6";
    endfunction

    initial begin
        bit          prev_line = 1'b0;
        bit          prev_act = 1'b0;
        bit          last = 1'b0;
        int          run = 0;
        int          idx = 0;
        int          pkts = 0;
        int          gap_cnt = 0;
        int          cyc = 0;
        bit          pkt_mode = 1'b0;
        bit          d;
        logic [14:0] lf = SEED;
        void'($urandom(32'd1234));

        // R1: quiet outputs while in reset, even with test_mode moving.
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            test_mode = k[0];
            if (k > 0) check(!line_out && !pkt_active, "R1 reset", {line_out, pkt_active}, 0);
        end
        test_mode = pkt_mode;
        @(negedge clk);
        rst_n = 1'b1;

        while (pkts < NPKT) begin
            @(negedge clk);
            cyc++;
            if (cyc > 20000) begin
                check(1'b0, "watchdog", cyc, 20000);
                break;
            end
            if (pkt_active) begin
                if (!prev_act) begin
                    // R1 on the first packet; R9 gap length and R8 start level afterwards.
                    if (pkts > 0) check(gap_cnt == GAP + 1, "R9 gap", gap_cnt, GAP + 1);
                    check(prev_line == 1'b0, "R8 start level", prev_line, 0);
                    idx = 0; run = 0; lf = SEED;
                end
                d = line_out ^ prev_line;
                if (run == MAXRUN) begin
                    check(d != last, "R7 stuff", d, !last);
                    last = d; run = 1;
                end else begin
                    check(d == exp_bit(idx, pkt_mode, lf), seg_req(idx, pkt_mode), d,
                          exp_bit(idx, pkt_mode, lf));
                    if (run > 0 && d == last) run++; else run = 1;
                    last = d;
                    if (idx >= HDR + MARK) lf = lfsr_next(lf);
                    idx++;
                end
                // R6: random mode noise except around the capture edge.
                if (idx < 60 || idx >= HDR + MARK) test_mode = 1'($urandom % 2);
                else test_mode = pkt_mode;
            end else begin
                if (prev_act) begin
                    check(idx == HDR + MARK + BODY, "R4 length", idx, HDR + MARK + BODY);
                    pkts++;
                    gap_cnt = 0;
                    case (pkts)
                        1: pkt_mode = 1'b1;
                        2: pkt_mode = 1'b0;
                        default: pkt_mode = 1'($urandom % 2);
                    endcase
                    test_mode = pkt_mode;
                end
                gap_cnt++;
                check(!pkt_active, "R9 idle", pkt_active, 0);
            end
            prev_line = line_out;
            prev_act = pkt_active;
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule